// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. A character of up to nine bits is offered through a valid/ready handshake, and three configuration inputs choose the frame shape at that moment: the number of data bits (five to nine), whether a parity bit is added and of which sense, and whether one or two stop bits close the frame. The line rests high between frames and a busy flag shows when a frame is on the wire.

Timing comes from an external tick enable that is produced elsewhere at sixteen times the bit rate. Every serial bit lasts exactly sixteen tick pulses. The frame shape and data are latched when the start bit begins, so a host may change the configuration inputs at any time without disturbing the frame in flight. When a new character waits at the end of a frame, its start bit follows the last stop bit with no idle time in between.

Top module: `serial_frame_tx`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `tx_out` is 1, `busy` is 0 and `in_ready` is 1.
- R2: Each accepted frame begins, in the cycle after acceptance, with a start bit of value 0. Every bit of a frame, including the start bit, is held on the registered `tx_out` for exactly 16 pulses of `tick`, and `tx_out` changes only on a `tick` or on an acceptance.
- R3: Data bits follow the start bit least significant first. The number of data bits is `cfg_size`, where values below 5 count as 5 and values above 9 count as 9. Input bits at or above that size never appear on the line.
- R4: `cfg_parity` encodes 0 = no parity, 1 = even, 2 = odd, 3 = no parity. With parity, a single bit follows the last data bit; even parity is the XOR of the sent data bits, odd parity its inverse. Data bits at or above the size do not take part.
- R5: One stop bit of value 1 follows the data (or parity) bit, and a second one follows when `cfg_two_stop` is 1.
- R6: When no frame is in progress, `busy` is 0, `tx_out` is 1 and `in_ready` is 1.
- R7: `in_ready` is 1 during a frame only in the cycle holding the 16th tick of the last stop bit; a character accepted there starts its start bit in the next cycle with no idle bit between frames.
- R8: Data and configuration are captured at acceptance; changes on `in_data`, `cfg_size`, `cfg_parity` or `cfg_two_stop` during a frame do not alter that frame.
- R9: In every other cycle of a frame `in_ready` is 0 and `in_valid` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Bit-rate enable, 16 pulses per serial bit |
| in_valid | input | 1 | A character is offered |
| in_ready | output | 1 | The offered character is taken at this clock edge |
| in_data | input | 9 | Character, bit 0 sent first |
| cfg_size | input | 4 | Data bit count, clamped to 5..9 |
| cfg_parity | input | 2 | Parity mode, 0 none, 1 even, 2 odd, 3 none |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| tx_out | output | 1 | Registered serial line, high when idle |
| busy | output | 1 | A frame is being sent |

## Verification
The bench builds the block with its defaults: nine bits at most, five at least and sixteen ticks per bit, so the full frame of thirteen bits and both clamping edges of the size input are reachable. Sizes 4 to 10 are swept against all four parity codes and both stop counts with random nine-bit data, which exposes masking of unused bits and the reserved parity code. Tick patterns of every cycle, every third cycle and random spacing, together with held-valid bursts whose configuration changes right after acceptance, cover the gapless hand-over at the end of the last stop bit and the capture of the frame shape.

// File: rtl/sft_pkg.sv
package sft_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_RSVD = 2'd3
  } parity_e;
endpackage

// File: rtl/sft_bit_timer.sv
module sft_bit_timer #(
  parameter int TICKS_PER_BIT = 16,
  parameter int CNT_W         = $clog2(TICKS_PER_BIT)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic bit_done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign bit_done = run && tick && (cnt == LAST);
endmodule

// File: rtl/sft_frame_builder.sv
module sft_frame_builder
  import sft_pkg::*;
#(
  parameter int DATA_MAX = 9,
  parameter int DATA_MIN = 5,
  parameter int SIZE_W   = $clog2(DATA_MAX + 1),
  parameter int FRAME_W  = DATA_MAX + 4,
  parameter int LEN_W    = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_MAX-1:0] in_data,
  input  logic [SIZE_W-1:0]   cfg_size,
  input  logic [1:0]          cfg_parity,
  input  logic                cfg_two_stop,
  output logic [FRAME_W-1:0]  frame_vec,
  output logic [LEN_W-1:0]    frame_len
);
  logic [SIZE_W-1:0]   eff_size;
  logic [DATA_MAX-1:0] masked;
  logic                par_en;
  logic                par_odd;
  logic                par_bit;
  parity_e             pmode;

  always_comb begin
    if (cfg_size < SIZE_W'(DATA_MIN))      eff_size = SIZE_W'(DATA_MIN);
    else if (cfg_size > SIZE_W'(DATA_MAX)) eff_size = SIZE_W'(DATA_MAX);
    else                                   eff_size = cfg_size;
  end

  for (genvar i = 0; i < DATA_MAX; i++) begin : g_mask
    assign masked[i] = in_data[i] & (eff_size > SIZE_W'(i));
  end

  assign pmode   = parity_e'(cfg_parity);
  assign par_en  = (pmode == PAR_EVEN) || (pmode == PAR_ODD);
  assign par_odd = (pmode == PAR_ODD);
  assign par_bit = (^masked) ^ par_odd;

  always_comb begin
    frame_vec    = '1;
    frame_vec[0] = 1'b0;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (SIZE_W'(i) < eff_size) frame_vec[i+1] = masked[i];
    end
    for (int p = 1; p < FRAME_W; p++) begin
      if (par_en && (p == int'(eff_size) + 1)) frame_vec[p] = par_bit;
    end
  end

  assign frame_len = LEN_W'(eff_size) + LEN_W'(par_en) + LEN_W'(cfg_two_stop) + LEN_W'(2);
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int DATA_MAX      = 9,
  parameter int DATA_MIN      = 5,
  parameter int TICKS_PER_BIT = 16,
  parameter int SIZE_W        = $clog2(DATA_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_MAX-1:0] in_data,
  input  logic [SIZE_W-1:0]   cfg_size,
  input  logic [1:0]          cfg_parity,
  input  logic                cfg_two_stop,
  output logic                tx_out,
  output logic                busy
);
  localparam int FRAME_W = DATA_MAX + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame_vec;
  logic [LEN_W-1:0]   frame_len;
  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   bits_left;
  logic               bit_done;
  logic               last_bit;
  logic               accept;

  sft_frame_builder #(
    .DATA_MAX(DATA_MAX), .DATA_MIN(DATA_MIN), .SIZE_W(SIZE_W),
    .FRAME_W(FRAME_W), .LEN_W(LEN_W)
  ) i_builder (
    .in_data(in_data), .cfg_size(cfg_size), .cfg_parity(cfg_parity),
    .cfg_two_stop(cfg_two_stop), .frame_vec(frame_vec), .frame_len(frame_len)
  );

  sft_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) i_timer (
    .clk(clk), .rst(rst), .run(busy), .restart(accept),
    .tick(tick), .bit_done(bit_done)
  );

  assign last_bit = (bits_left == LEN_W'(1));
  assign in_ready = !busy || (bit_done && last_bit);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      tx_out    <= 1'b1;
      shreg     <= '1;
      bits_left <= '0;
    end else if (accept) begin
      busy      <= 1'b1;
      shreg     <= frame_vec;
      tx_out    <= frame_vec[0];
      bits_left <= frame_len;
    end else if (bit_done) begin
      if (last_bit) begin
        busy      <= 1'b0;
        tx_out    <= 1'b1;
        bits_left <= '0;
      end else begin
        shreg     <= {1'b1, shreg[FRAME_W-1:1]};
        tx_out    <= shreg[1];
        bits_left <= bits_left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sft_checker.sv
module sft_checker (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic in_valid,
  input logic in_ready,
  input logic tx_out,
  input logic busy
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx_out); // R6

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
    !busy |-> in_ready); // R6

  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (busy && !tx_out)); // R7

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
    (!tick && !(in_valid && in_ready)) |=> $stable(tx_out)); // R2

  AST_BUSY_READY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (busy && in_ready) |-> tick); // R9
endmodule

bind serial_frame_tx sft_checker i_sft_checker (
  .clk(clk), .rst(rst), .tick(tick), .in_valid(in_valid),
  .in_ready(in_ready), .tx_out(tx_out), .busy(busy)
);

// File: tb/test_serial_frame_tx.sv
`timescale 1ns/100ps
module test_serial_frame_tx;
  logic       clk = 0;
  logic       rst = 1;
  logic       tick = 0;
  logic       in_valid = 0;
  logic       in_ready;
  logic [8:0] in_data = '0;
  logic [3:0] cfg_size = 4'd8;
  logic [1:0] cfg_parity = 2'd0;
  logic       cfg_two_stop = 0;
  logic       tx_out;
  logic       busy;

  int checks = 0;
  int errors = 0;
  int tick_mode = 0;
  int phase = 0;
  bit seen_edge = 0;

  int q_bit[$];
  int q_kind[$];
  int m_cnt = 0;
  bit m_busy = 0;
  bit m_line = 1;

  serial_frame_tx i_serial_frame_tx (
    .clk(clk), .rst(rst), .tick(tick), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_size(cfg_size), .cfg_parity(cfg_parity),
    .cfg_two_stop(cfg_two_stop), .tx_out(tx_out), .busy(busy)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  function automatic void build(input logic [8:0] d, input logic [3:0] s,
                                input logic [1:0] p, input logic two);
    int eff;
    int par;
    eff = (s < 5) ? 5 : ((s > 9) ? 9 : int'(s));
    par = 0;
    q_bit.delete();
    q_kind.delete();
    q_bit.push_back(0); q_kind.push_back(0);
    for (int i = 0; i < eff; i++) begin
      q_bit.push_back(int'(d[i])); q_kind.push_back(1);
      par = par ^ int'(d[i]);
    end
    if (p == 2'd1 || p == 2'd2) begin
      q_bit.push_back(par ^ ((p == 2'd2) ? 1 : 0)); q_kind.push_back(2);
    end
    q_bit.push_back(1); q_kind.push_back(3);
    if (two) begin
      q_bit.push_back(1); q_kind.push_back(3);
    end
  endfunction

  // Reference model, advanced on each rising edge
  always @(posedge clk) begin
    bit adv;
    bit rdy;
    seen_edge = 1;
    if (rst) begin
      m_busy = 0; m_line = 1; m_cnt = 0;
      q_bit.delete(); q_kind.delete();
    end else begin
      adv = m_busy && tick && (m_cnt == 15);
      rdy = !m_busy || (adv && q_bit.size() == 1);
      if (m_busy && tick) m_cnt = (m_cnt + 1) % 16;
      if (adv) begin
        void'(q_bit.pop_front());
        void'(q_kind.pop_front());
      end
      if (rdy && in_valid) begin
        build(in_data, cfg_size, cfg_parity, cfg_two_stop);
        m_cnt = 0; m_busy = 1; m_line = q_bit[0][0];
      end else if (adv) begin
        if (q_bit.size() == 0) begin
          m_busy = 0; m_line = 1;
        end else begin
          m_line = q_bit[0][0];
        end
      end
    end
  end

  // Comparison away from the active edge
  always @(negedge clk) begin
    bit    m_rdy;
    bit    at_end;
    string tag;
    if (seen_edge) begin
      if (rst) begin
        check(tx_out === 1'b1, "R1 tx_out", tx_out, 1);
        check(busy === 1'b0, "R1 busy", busy, 0);
        check(in_ready === 1'b1, "R1 in_ready", in_ready, 1);
      end else begin
        at_end = m_busy && tick && (m_cnt == 15) && (q_bit.size() == 1);
        m_rdy  = !m_busy || at_end;
        if (!m_busy) tag = "R6 idle line";
        else case (q_kind[0])
          0: tag = "R2 start bit";
          1: tag = "R3/R8 data bit";
          2: tag = "R4 parity bit";
          default: tag = "R5 stop bit";
        endcase
        check(tx_out === m_line, tag, tx_out, m_line);
        check(busy === m_busy, "R6 busy", busy, m_busy);
        if (!m_busy) tag = "R6 ready idle";
        else if (at_end) tag = "R7 ready at frame end";
        else tag = "R9 ready in frame";
        check(in_ready === m_rdy, tag, in_ready, m_rdy);
      end
    end
  end

  // Tick enable generator
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      #1;
      k++;
      case (tick_mode)
        0: tick = 1'b1;
        1: tick = (k % 3 == 0);
        default: tick = $urandom_range(0, 1) == 1;
      endcase
    end
  end

  task automatic send(input logic [8:0] d, input logic [3:0] s, input logic [1:0] p,
                      input logic two, input bit keep);
    @(negedge clk);
    #2;
    in_valid = 1; in_data = d; cfg_size = s; cfg_parity = p; cfg_two_stop = two;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1;
    if (!keep) begin
      in_valid = 0;
      in_data = 9'($urandom);
      cfg_size = 4'($urandom);
      cfg_parity = 2'($urandom);
      cfg_two_stop = 1'($urandom);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    phase = 1;
    // R3 R4 R5: sweep of sizes (including clamped values), parity codes, stop counts
    for (int s = 4; s <= 10; s++)
      for (int p = 0; p < 4; p++)
        for (int t = 0; t < 2; t++) begin
          send(9'($urandom), 4'(s), 2'(p), 1'(t), 0);
          wait_idle();
        end
    send(9'h1FF, 4'd0, 2'd1, 1'b0, 0);
    wait_idle();
    send(9'h155, 4'd15, 2'd2, 1'b1, 0);
    wait_idle();
    // R7 R8: back-to-back bursts, configuration changes right after acceptance
    phase = 2;
    tick_mode = 1;
    for (int n = 0; n < 6; n++)
      send(9'($urandom), 4'($urandom_range(5, 9)), 2'($urandom), 1'($urandom), 1);
    in_valid = 0;
    wait_idle();
    tick_mode = 2;
    for (int n = 0; n < 6; n++)
      send(9'($urandom), 4'($urandom), 2'($urandom), 1'($urandom), n != 5);
    in_valid = 0;
    wait_idle();
    tick_mode = 0;
    for (int n = 0; n < 4; n++)
      send(9'($urandom), 4'd9, 2'd2, 1'b1, 1);
    in_valid = 0;
    wait_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog: actual running expected finished in phase %0d", phase);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule